// File: doc/BRIEF.md
# Endpoint-zero control and status register

This block holds the firmware-visible handshake state of the control endpoint in a USB device controller. The block keeps six status flags: received packet waiting, transmit packet armed, data phase finished, transfer cut short, stall handshake sent, and stall request. The serial engine updates the flags through one-cycle event pulses. Firmware updates them through a small register write interface.

The register sits on a simple CPU register bus. It answers only when the endpoint index register holds zero. For any other index, the same address belongs to the IN control register of another endpoint, and this block ignores the access.

Firmware clears the receive flag and the cut-short flag through dedicated strobe bits, not by writing the flags themselves. Clearing the cut-short flag also flushes the endpoint FIFO and blocks FIFO access until the next packet arrives. Several engine events move the data-end, transmit and receive flags together, in the same clock cycle.

Top module: `ep0_csr`

## Requirements
- R1: After a synchronous active-high reset, all flags are 0, `bus_rdata` is 0, and `stall_o`, `fifo_flush_o` and `fifo_blocked_o` are 0.
- R2: An access counts only when `bus_sel` is high and `bus_idx` is zero. Otherwise a write changes nothing, and a read returns 0 in the next cycle.
- R3: A read returns its data one cycle later. The data is taken from the flag state before that cycle's updates. Bit 0 is the received-packet flag, bit 1 the transmit-armed flag, bit 2 stall-sent, bit 3 data-end, bit 4 setup-end and bit 5 stall request. Bits 6, 7 and 15:8 always read 0.
- R4: Writing 1 to bit 7 clears setup-end. The same write raises `fifo_flush_o` for exactly the next cycle. It also raises `fifo_blocked_o`, which stays high until `se_rx_pkt` arrives; if the write and the pulse coincide, it stays high.
- R5: Writing 1 to bit 6 clears the received-packet flag.
- R6: Any counted write loads bit 5 into the stall request, and `stall_o` follows it from the next cycle.
- R7: `se_bad_token` clears the received-packet flag only while the stall request is 1. When the stall request is 0, the pulse has no effect.
- R8: `se_early_end` sets setup-end only if data-end is 0 in that cycle.
- R9: `se_last_load` sets data-end and the transmit-armed flag. `se_last_unload` sets data-end and clears the received-packet flag. `se_zero_len` sets data-end and the transmit-armed flag and clears the received-packet flag, all in one cycle.
- R10: `se_proto_err` sets stall-sent. Writing 1 to bit 2 clears it. If both happen in the same cycle, the set wins.
- R11: `se_rx_pkt` sets the received-packet flag and wins over every clear in the same cycle. `se_tx_done` clears the transmit-armed flag, and writing 1 to bit 1 sets it, with the set winning. `se_status_done` clears data-end, and any data-end set in the same cycle wins.
- R12: Writes to bits 0, 3 and 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access targets the shared register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_idx | input | IDX_W | Current endpoint index register value |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, 0 when not addressed |
| se_rx_pkt | input | 1 | Engine pulse: OUT or SETUP packet received |
| se_tx_done | input | 1 | Engine pulse: IN packet sent |
| se_last_load | input | 1 | Engine pulse: last transmit packet loaded |
| se_last_unload | input | 1 | Engine pulse: last receive packet unloaded |
| se_zero_len | input | 1 | Engine pulse: zero-length data phase |
| se_early_end | input | 1 | Engine pulse: control transfer ended early |
| se_bad_token | input | 1 | Engine pulse: invalid token decoded |
| se_proto_err | input | 1 | Engine pulse: transaction ended by protocol violation |
| se_status_done | input | 1 | Engine pulse: status stage complete |
| stall_o | output | 1 | Stall handshake request to the engine |
| fifo_flush_o | output | 1 | One-cycle FIFO flush request |
| fifo_blocked_o | output | 1 | FIFO access blocked |

## Verification
The bench drives its stimulus against a cycle model. It focuses on events that collide in one cycle.

- A new packet arriving with a firmware clear: a design that let the clear win would lose the packet.
- A stall-sent clear meeting a protocol error: a wrong priority would hide the stall report.
- An early transfer end arriving after data-end: a design without the data-end gate would flag a false setup-end.

Other cases target the access gating. A write with a non-zero endpoint index must not disturb stall or FIFO state. The strobe bits must read back as zero. An invalid token with no stall active must leave the received flag set.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;

  // Bit positions inside the register; firmware decodes these.
  localparam int B_OUT   = 0;
  localparam int B_IN    = 1;
  localparam int B_SSENT = 2;
  localparam int B_DEND  = 3;
  localparam int B_SEND  = 4;
  localparam int B_STALL = 5;
  localparam int B_CLOUT = 6;
  localparam int B_CLSE  = 7;
  localparam int USED_W  = 8;

  // Decoded effects of one firmware write.
  typedef struct packed {
    logic clr_send;   // bit 7 strobe
    logic clr_out;    // bit 6 strobe
    logic stall_ld;   // load stall request
    logic stall_val;  // value loaded
    logic clr_ssent;  // bit 2 write-one-clear
    logic set_in;     // bit 1 write-one-set
  } wr_fx_t;

  // Flag state.
  typedef struct packed {
    logic stall;
    logic send;
    logic dend;
    logic ssent;
    logic in_rdy;
    logic out_rdy;
  } flags_t;

endpackage

// File: rtl/ep0_csr_wdec.sv
module ep0_csr_wdec
  import ep0_csr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output wr_fx_t            wr_fx,
  output logic              rd_hit
);

  logic hit;

  assign hit    = bus_sel && (bus_idx == '0);
  assign rd_hit = hit && bus_rd;

  always_comb begin
    wr_fx           = '0;
    if (hit && bus_wr) begin
      wr_fx.clr_send  = bus_wdata[B_CLSE];
      wr_fx.clr_out   = bus_wdata[B_CLOUT];
      wr_fx.stall_ld  = 1'b1;
      wr_fx.stall_val = bus_wdata[B_STALL];
      wr_fx.clr_ssent = bus_wdata[B_SSENT];
      wr_fx.set_in    = bus_wdata[B_IN];
    end
  end

endmodule

// File: rtl/ep0_flag.sv
module ep0_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  // Set has priority over clear.
  always_ff @(posedge clk) begin
    if (rst)        q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

endmodule

// File: rtl/ep0_csr_flags.sv
module ep0_csr_flags
  import ep0_csr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  wr_fx_t wr_fx,
  input  logic   se_rx_pkt,
  input  logic   se_tx_done,
  input  logic   se_last_load,
  input  logic   se_last_unload,
  input  logic   se_zero_len,
  input  logic   se_early_end,
  input  logic   se_bad_token,
  input  logic   se_proto_err,
  input  logic   se_status_done,
  output flags_t flags
);

  localparam int NF = 5;

  logic [NF-1:0] set_v, clr_v, q_v;

  // index 0 out_rdy, 1 in_rdy, 2 ssent, 3 dend, 4 send
  always_comb begin
    set_v[0] = se_rx_pkt;
    clr_v[0] = wr_fx.clr_out | (se_bad_token & flags.stall)
             | se_last_unload | se_zero_len;
    set_v[1] = se_last_load | se_zero_len | wr_fx.set_in;
    clr_v[1] = se_tx_done;
    set_v[2] = se_proto_err;
    clr_v[2] = wr_fx.clr_ssent;
    set_v[3] = se_last_load | se_last_unload | se_zero_len;
    clr_v[3] = se_status_done;
    set_v[4] = se_early_end & ~flags.dend;
    clr_v[4] = wr_fx.clr_send;
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    ep0_flag #(.RST_VAL(1'b0)) u_flag (
      .clk  (clk),
      .rst  (rst),
      .set_i(set_v[i]),
      .clr_i(clr_v[i]),
      .q_o  (q_v[i])
    );
  end

  logic stall_q;

  always_ff @(posedge clk) begin
    if (rst)                stall_q <= 1'b0;
    else if (wr_fx.stall_ld) stall_q <= wr_fx.stall_val;
  end

  assign flags.out_rdy = q_v[0];
  assign flags.in_rdy  = q_v[1];
  assign flags.ssent   = q_v[2];
  assign flags.dend    = q_v[3];
  assign flags.send    = q_v[4];
  assign flags.stall   = stall_q;

endmodule

// File: rtl/ep0_fifo_guard.sv
module ep0_fifo_guard (
  input  logic clk,
  input  logic rst,
  input  logic clr_send,
  input  logic se_rx_pkt,
  output logic flush_o,
  output logic blocked_o
);

  always_ff @(posedge clk) begin
    if (rst) flush_o <= 1'b0;
    else     flush_o <= clr_send;
  end

  ep0_flag #(.RST_VAL(1'b0)) u_block (
    .clk  (clk),
    .rst  (rst),
    .set_i(clr_send),
    .clr_i(se_rx_pkt),
    .q_o  (blocked_o)
  );

endmodule

// File: rtl/ep0_csr.sv
module ep0_csr
  import ep0_csr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              se_rx_pkt,
  input  logic              se_tx_done,
  input  logic              se_last_load,
  input  logic              se_last_unload,
  input  logic              se_zero_len,
  input  logic              se_early_end,
  input  logic              se_bad_token,
  input  logic              se_proto_err,
  input  logic              se_status_done,
  output logic              stall_o,
  output logic              fifo_flush_o,
  output logic              fifo_blocked_o
);

  wr_fx_t wr_fx;
  logic   rd_hit;
  flags_t flags;
  logic [USED_W-1:0] view;

  ep0_csr_wdec #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_wdec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_idx  (bus_idx),
    .bus_wdata(bus_wdata),
    .wr_fx    (wr_fx),
    .rd_hit   (rd_hit)
  );

  ep0_csr_flags u_flags (
    .clk           (clk),
    .rst           (rst),
    .wr_fx         (wr_fx),
    .se_rx_pkt     (se_rx_pkt),
    .se_tx_done    (se_tx_done),
    .se_last_load  (se_last_load),
    .se_last_unload(se_last_unload),
    .se_zero_len   (se_zero_len),
    .se_early_end  (se_early_end),
    .se_bad_token  (se_bad_token),
    .se_proto_err  (se_proto_err),
    .se_status_done(se_status_done),
    .flags         (flags)
  );

  ep0_fifo_guard u_guard (
    .clk      (clk),
    .rst      (rst),
    .clr_send (wr_fx.clr_send),
    .se_rx_pkt(se_rx_pkt),
    .flush_o  (fifo_flush_o),
    .blocked_o(fifo_blocked_o)
  );

  always_comb begin
    view          = '0;
    view[B_OUT]   = flags.out_rdy;
    view[B_IN]    = flags.in_rdy;
    view[B_SSENT] = flags.ssent;
    view[B_DEND]  = flags.dend;
    view[B_SEND]  = flags.send;
    view[B_STALL] = flags.stall;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= {{(DATA_W-USED_W){1'b0}}, view};
    else             bus_rdata <= '0;
  end

  assign stall_o = flags.stall;

endmodule

// File: rtl/ep0_csr_chk.sv
module ep0_csr_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [IDX_W-1:0]  bus_idx,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              se_rx_pkt,
  input logic              se_zero_len,
  input logic              se_early_end,
  input logic              se_proto_err,
  input logic              stall_o,
  input logic              fifo_flush_o,
  input logic              fifo_blocked_o,
  input logic              f_out,
  input logic              f_in,
  input logic              f_dend,
  input logic              f_send,
  input logic              f_ssent
);

  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    fifo_flush_o |-> fifo_blocked_o); // R4

  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_idx != '0) |=> $stable(stall_o)); // R2

  AST_STALL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_idx == '0) |=> stall_o == $past(bus_wdata[5])); // R6

  AST_STROBES_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:6] == '0); // R3

  AST_PROTO_SETS: assert property (@(posedge clk) disable iff (rst)
    se_proto_err |=> f_ssent); // R10

  AST_RX_WINS: assert property (@(posedge clk) disable iff (rst)
    se_rx_pkt |=> f_out); // R11

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (se_zero_len && !se_rx_pkt) |=> (f_dend && f_in && !f_out)); // R9

  AST_EARLY_GATED: assert property (@(posedge clk) disable iff (rst)
    (se_early_end && f_dend && !f_send) |=> !f_send); // R8

endmodule

bind ep0_csr ep0_csr_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_sel       (bus_sel),
  .bus_wr        (bus_wr),
  .bus_idx       (bus_idx),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .se_rx_pkt     (se_rx_pkt),
  .se_zero_len   (se_zero_len),
  .se_early_end  (se_early_end),
  .se_proto_err  (se_proto_err),
  .stall_o       (stall_o),
  .fifo_flush_o  (fifo_flush_o),
  .fifo_blocked_o(fifo_blocked_o),
  .f_out         (flags.out_rdy),
  .f_in          (flags.in_rdy),
  .f_dend        (flags.dend),
  .f_send        (flags.send),
  .f_ssent       (flags.ssent)
);

// File: tb/ep0_csr_tb.sv
module ep0_csr_tb;

  localparam int DW = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst;
  logic bus_sel, bus_wr, bus_rd;
  logic [IW-1:0] bus_idx;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic rx, tx, lload, lunload, zlen, early, badt, perr, sdone;
  logic stall_o, fifo_flush_o, fifo_blocked_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // model state
  bit m_out, m_in, m_ss, m_de, m_se, m_st, m_lock, m_flush;
  logic [DW-1:0] m_rd;

  always #10 clk = ~clk;

  ep0_csr #(.DATA_W(DW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .se_rx_pkt(rx), .se_tx_done(tx), .se_last_load(lload),
    .se_last_unload(lunload), .se_zero_len(zlen), .se_early_end(early),
    .se_bad_token(badt), .se_proto_err(perr), .se_status_done(sdone),
    .stall_o(stall_o), .fifo_flush_o(fifo_flush_o),
    .fifo_blocked_o(fifo_blocked_o)
  );

  function automatic logic [DW-1:0] pack_view();
    logic [DW-1:0] v = '0;
    v[0] = m_out; v[1] = m_in; v[2] = m_ss;
    v[3] = m_de;  v[4] = m_se; v[5] = m_st;
    return v;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_idx = '0; bus_wdata = '0;
    rx = 0; tx = 0; lload = 0; lunload = 0; zlen = 0;
    early = 0; badt = 0; perr = 0; sdone = 0;
  endtask

  // Drive current inputs for one cycle, advance model, compare outputs.
  task automatic step();
    bit hit, w;
    bit n_out, n_in, n_ss, n_de, n_se, n_st, n_lock;
    hit = bus_sel && (bus_idx == '0);
    w   = hit && bus_wr;
    m_rd = (hit && bus_rd) ? pack_view() : '0;
    n_out = rx ? 1'b1 : ((w && bus_wdata[6]) || (badt && m_st) || lunload || zlen) ? 1'b0 : m_out;
    n_in  = (lload || zlen || (w && bus_wdata[1])) ? 1'b1 : tx ? 1'b0 : m_in;
    n_ss  = perr ? 1'b1 : (w && bus_wdata[2]) ? 1'b0 : m_ss;
    n_de  = (lload || lunload || zlen) ? 1'b1 : sdone ? 1'b0 : m_de;
    n_se  = (early && !m_de) ? 1'b1 : (w && bus_wdata[7]) ? 1'b0 : m_se;
    n_st  = w ? bus_wdata[5] : m_st;
    n_lock = (w && bus_wdata[7]) ? 1'b1 : rx ? 1'b0 : m_lock;
    m_flush = w && bus_wdata[7];
    m_out = n_out; m_in = n_in; m_ss = n_ss; m_de = n_de;
    m_se = n_se; m_st = n_st; m_lock = n_lock;
    @(posedge clk);
    #1;
    cycles++;
    chk("R3 rdata", bus_rdata, m_rd);
    chk("R6 stall_o", {15'b0, stall_o}, {15'b0, m_st});
    chk("R4 fifo_flush_o", {15'b0, fifo_flush_o}, {15'b0, m_flush});
    chk("R4 fifo_blocked_o", {15'b0, fifo_blocked_o}, {15'b0, m_lock});
    @(negedge clk);
  endtask

  // Read and check the named field after the current state.
  task automatic read_field(input string req, input int bitpos);
    logic [DW-1:0] exp;
    idle_inputs();
    bus_sel = 1; bus_rd = 1;
    exp = pack_view();
    step();
    chk(req, {15'b0, bus_rdata[bitpos]}, {15'b0, exp[bitpos]});
  endtask

  task automatic wr(input logic [DW-1:0] d);
    idle_inputs();
    bus_sel = 1; bus_wr = 1; bus_wdata = d;
    step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
      end
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_out = 0; m_in = 0; m_ss = 0; m_de = 0; m_se = 0; m_st = 0; m_lock = 0; m_flush = 0;
    // R1 reset state
    chk("R1 rdata", bus_rdata, '0);
    chk("R1 stall", {15'b0, stall_o}, '0);
    chk("R1 flush", {15'b0, fifo_flush_o}, '0);
    chk("R1 blocked", {15'b0, fifo_blocked_o}, '0);
    read_field("R1 flags zero", 0);
    chk("R1 full read", bus_rdata, '0);

    // R11 rx sets out, R5 strobe clears
    idle_inputs(); rx = 1; step();
    read_field("R11 out set", 0);
    wr(16'h0040);
    read_field("R5 out cleared", 0);
    // R11 rx wins over clear strobe
    idle_inputs(); bus_sel = 1; bus_wr = 1; bus_wdata = 16'h0040; rx = 1; step();
    read_field("R11 rx wins", 0);
    // R12 writes to bits 0,3,4 ignored
    wr(16'h0019);
    read_field("R12 bit0 kept", 0);
    read_field("R12 dend stays 0", 3);
    read_field("R12 send stays 0", 4);
    // R7 bad token without stall ignored
    idle_inputs(); badt = 1; step();
    read_field("R7 no stall keeps out", 0);
    // R6 stall, R7 bad token with stall clears out
    wr(16'h0020);
    idle_inputs(); badt = 1; step();
    read_field("R7 stall clears out", 0);
    wr(16'h0000);
    // R2 foreign index write ignored
    idle_inputs(); bus_sel = 1; bus_wr = 1; bus_idx = 4'd3; bus_wdata = 16'h00A0; step();
    idle_inputs(); bus_sel = 1; bus_rd = 1; bus_idx = 4'd2; step();
    chk("R2 foreign read zero", bus_rdata, '0);
    // R8 early end with dend clear
    idle_inputs(); early = 1; step();
    read_field("R8 send set", 4);
    // R4 clear-setup-end strobe, flush, block
    wr(16'h0080);
    read_field("R4 send cleared", 4);
    idle_inputs(); rx = 1; step();
    // R9 zero length
    idle_inputs(); zlen = 1; step();
    read_field("R9 zlen dend", 3);
    read_field("R9 zlen in", 1);
    read_field("R9 zlen out", 0);
    // R8 early end gated by dend
    idle_inputs(); early = 1; step();
    read_field("R8 gated by dend", 4);
    // R11 status done clears dend, tx clears in
    idle_inputs(); sdone = 1; tx = 1; step();
    read_field("R11 dend cleared", 3);
    read_field("R11 in cleared", 1);
    // R9 last load and unload
    idle_inputs(); lload = 1; step();
    read_field("R9 load in", 1);
    idle_inputs(); rx = 1; step();
    idle_inputs(); lunload = 1; step();
    read_field("R9 unload out", 0);
    // R10 proto err set, clear, set wins
    idle_inputs(); perr = 1; step();
    read_field("R10 ssent set", 2);
    wr(16'h0004);
    read_field("R10 ssent cleared", 2);
    idle_inputs(); bus_sel = 1; bus_wr = 1; bus_wdata = 16'h0004; perr = 1; step();
    read_field("R10 set wins", 2);
    // R11 firmware arms transmit
    wr(16'h0002);
    read_field("R11 in armed", 1);

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      idle_inputs();
      bus_sel = ($urandom_range(7) != 0);
      bus_rd  = 1;
      bus_wr  = ($urandom_range(3) == 0);
      bus_idx = ($urandom_range(3) == 0) ? IW'($urandom_range(15)) : '0;
      bus_wdata = DW'($urandom);
      rx = ($urandom_range(7) == 0); tx = ($urandom_range(7) == 0);
      lload = ($urandom_range(9) == 0); lunload = ($urandom_range(9) == 0);
      zlen = ($urandom_range(11) == 0); early = ($urandom_range(7) == 0);
      badt = ($urandom_range(7) == 0); perr = ($urandom_range(9) == 0);
      sdone = ($urandom_range(7) == 0);
      step();
    end
    summary();
  end

endmodule